// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt events from up to eleven peripherals into a pending-status register. A CPU reaches that register and an enable-mask register over a simple register bus, with both 32-bit and 16-bit accesses. A single-cycle pulse on an event input marks the matching status bit as pending. Software acknowledges pending bits with an AND-style write, in which every bit written as zero is cleared.

The block drives one interrupt request line toward the CPU. The line is high whenever a pending bit is also enabled in the mask. It follows the masked status after one register stage, so a mask write that uncovers an already-pending bit raises the request without waiting for another event. One status bit, the sound source (bit 9 by default), can be configured so that a status write carrying a one in its position marks it pending.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset, the status and mask registers read as zero, `irq_req` is low and `bus_rdata` is zero.
- R2: A one on `evt_pulse[i]` in a cycle sets status bit i at that clock edge, and the bit reads back as one.
- R3: A write to the status register (offset 0x070) clears each status bit whose write-data bit is 0. A non-sound bit written as 1 keeps its old value and is never set by the write.
- R4: When an event pulse and a clearing status write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to the mask register (offset 0x074) stores the written value. Mask bits at positions NUM_SRC and above do not exist and read as zero.
- R6: `irq_req` equals the OR of (status AND mask) as it stood one clock earlier. A mask write that overlaps a pending bit raises `irq_req` one cycle after the write edge.
- R7: When `bus_wide`=0 the access is 16 bits wide. Bit 1 of the address picks the lower half (bits 15:0) or the upper half (bits 31:16). Such a write leaves the other half untouched, and such a read returns the selected half zero-extended in `bus_rdata[15:0]`.
- R8: With SND_REASSERT=1 (the default), a status write that has bit SND_BIT (default 9) set in its lane marks that status bit pending.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is high, and it holds its value in every cycle without a read.
- R10: Accesses whose word offset (address bits above bit 1) matches neither register change no state, and reads at such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | NUM_SRC (11) | Single-cycle event pulses, bit i feeds status bit i |
| bus_addr | input | ADDR_W (12) | Byte offset within the I/O page |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Combined interrupt request to the CPU |

## Verification
Status and mask change at the same clock edge that samples the event or write strobe, so their read-back is requested on the following cycle. Read data appears at the edge that samples `bus_rd` and is compared at the falling edge that follows. `irq_req` lags the register change by exactly one edge. The bench therefore checks it once right after a mask or status write, where it must still show the old value, and again one cycle later, where it must show the new value. All stimulus changes on falling edges and every comparison happens on a falling edge. Read expectations go into a queue when the read is issued and are popped when the design's read edge has passed.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants and types for the interrupt status/mask controller.
// Assumes a 32-bit register bus with 16-bit half-word lanes.
package irq_ctrl_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HALF_W = 16;

    // Which register a read targets.
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_STAT = 2'd1,
        RSEL_MASK = 2'd2
    } reg_id_t;

    // Per-register write-lane enables.
    typedef struct packed {
        logic lo;
        logic hi;
    } lane_wr_t;

endpackage

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Turns a bus address, strobes and access size into per-register lane write
// enables and a read selector. Assumes word-aligned register offsets; address
// bit 1 picks the half for 16-bit accesses and bit 0 is ignored.
module irq_bus_decode
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] STAT_OFFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFFS = 12'h074
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              wide,
    output lane_wr_t          stat_wr,
    output lane_wr_t          mask_wr,
    output reg_id_t           rd_sel,
    output logic              rd_upper
);

    localparam int unsigned WORD_MSB = ADDR_W - 1;

    logic hit_stat;
    logic hit_mask;
    logic lane_lo;
    logic lane_hi;

    // Word-offset match against each register.
    always_comb begin
        hit_stat = (addr[WORD_MSB:2] == STAT_OFFS[WORD_MSB:2]);
        hit_mask = (addr[WORD_MSB:2] == MASK_OFFS[WORD_MSB:2]);
    end

    // Lane selection: a wide access covers both halves.
    always_comb begin
        lane_lo = wide | ~addr[1];
        lane_hi = wide |  addr[1];
    end

    // Lane write enables per register.
    always_comb begin
        stat_wr.lo = wr & hit_stat & lane_lo;
        stat_wr.hi = wr & hit_stat & lane_hi;
        mask_wr.lo = wr & hit_mask & lane_lo;
        mask_wr.hi = wr & hit_mask & lane_hi;
    end

    // Read selector and half choice.
    always_comb begin
        if (rd && hit_stat)      rd_sel = RSEL_STAT;
        else if (rd && hit_mask) rd_sel = RSEL_MASK;
        else                     rd_sel = RSEL_NONE;
        rd_upper = ~wide & addr[1];
    end

endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Holds NUM_SRC pending bits. Each bit is set by its event pulse and cleared by
// a status write carrying 0 in that position. An event in the same cycle wins.
// The optional sound bit is also set by a write carrying 1 in its position.
// Assumes NUM_SRC <= 32; bits 0..15 live in the low lane, 16..31 in the high one.
module irq_status_bank
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC      = 11,
    parameter int unsigned SND_BIT      = 9,
    parameter bit          SND_REASSERT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  lane_wr_t           wr_en,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] stat
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic lane_hit;
        logic ack_clr;
        logic force_set;
        logic nxt;

        // Lane that covers this bit.
        if (i < HALF_W) begin : g_lo
            assign lane_hit = wr_en.lo;
        end else begin : g_hi
            assign lane_hit = wr_en.hi;
        end

        // Sound bit re-assertion through a status write (R8).
        if (SND_REASSERT && (i == SND_BIT)) begin : g_snd
            assign force_set = lane_hit & wdata[i];
        end else begin : g_plain
            assign force_set = 1'b0;
        end

        // Acknowledge: a written zero clears the bit (R3).
        assign ack_clr = lane_hit & ~wdata[i];

        // Next state: event has priority over acknowledge (R2, R4).
        always_comb begin
            nxt = evt[i] | force_set | (stat[i] & ~ack_clr);
        end

        // Pending-bit storage.
        always_ff @(posedge clk) begin
            if (!rst_n) stat[i] <= 1'b0;
            else        stat[i] <= nxt;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// Enable mask with per-lane writes. Stores the written value as is; only
// NUM_SRC bits exist. Assumes NUM_SRC <= 32.
module irq_mask_reg
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lane_wr_t           wr_en,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic lane_hit;

        // Lane that covers this bit.
        if (i < HALF_W) begin : g_lo
            assign lane_hit = wr_en.lo;
        end else begin : g_hi
            assign lane_hit = wr_en.hi;
        end

        // Mask bit storage (R5).
        always_ff @(posedge clk) begin
            if (!rst_n)        mask[i] <= 1'b0;
            else if (lane_hit) mask[i] <= wdata[i];
        end
    end

endmodule

// File: rtl/irq_req_out.sv
// Module: irq_req_out
// Registers the OR of pending-and-enabled bits into the request line, one clock
// after any change of status or mask. Assumes both vectors are NUM_SRC wide.
module irq_req_out #(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] stat,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq
);

    logic any_live;

    // Combine pending and enabled bits.
    always_comb begin
        any_live = |(stat & mask);
    end

    // Request register (R6).
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_live;
    end

endmodule

// File: rtl/irq_read_port.sv
// Module: irq_read_port
// Zero-extends the two registers to bus width, picks the addressed one and half,
// and registers the result on a read strobe. Assumes NUM_SRC <= 32.
module irq_read_port
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  reg_id_t            rd_sel,
    input  logic               rd_upper,
    input  logic               rd_wide,
    input  logic               rd_en,
    input  logic [NUM_SRC-1:0] stat,
    input  logic [NUM_SRC-1:0] mask,
    output logic [BUS_W-1:0]   rdata
);

    logic [BUS_W-1:0] stat_ext;
    logic [BUS_W-1:0] mask_ext;
    logic [BUS_W-1:0] src;
    logic [BUS_W-1:0] nxt;

    // Zero extension to bus width.
    for (genvar b = 0; b < BUS_W; b++) begin : g_ext
        if (b < NUM_SRC) begin : g_live
            assign stat_ext[b] = stat[b];
            assign mask_ext[b] = mask[b];
        end else begin : g_zero
            assign stat_ext[b] = 1'b0;
            assign mask_ext[b] = 1'b0;
        end
    end

    // Register choice (R10: unmatched offsets read zero).
    always_comb begin
        case (rd_sel)
            RSEL_STAT: src = stat_ext;
            RSEL_MASK: src = mask_ext;
            default:   src = '0;
        endcase
    end

    // Half choice for 16-bit reads (R7).
    always_comb begin
        if (rd_wide)       nxt = src;
        else if (rd_upper) nxt = {{HALF_W{1'b0}}, src[BUS_W-1:HALF_W]};
        else               nxt = {{HALF_W{1'b0}}, src[HALF_W-1:0]};
    end

    // Read data register, loads only on a read (R9).
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= nxt;
    end

endmodule

// File: rtl/irq_ctrl_unit.sv
// Module: irq_ctrl_unit (top)
// Memory-mapped interrupt status and mask controller. Event pulses set pending
// bits, software acknowledges them with AND-writes, and the request line
// reports any pending-and-enabled bit one clock later.
// Assumes NUM_SRC <= 32 and a synchronous active-low reset.
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC      = 11,
    parameter int unsigned ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] STAT_OFFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFFS = 12'h074,
    parameter int unsigned SND_BIT      = 9,
    parameter bit          SND_REASSERT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_wide,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               irq_req
);

    lane_wr_t           stat_wr;
    lane_wr_t           mask_wr;
    reg_id_t            rd_sel;
    logic               rd_upper;
    logic [NUM_SRC-1:0] wdata_live;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               unused_bits;

    // Only the implemented bit positions of the write data matter.
    assign wdata_live  = bus_wdata[NUM_SRC-1:0];
    assign unused_bits = ^{bus_wdata, bus_addr[0]};

    irq_bus_decode #(
        .ADDR_W    (ADDR_W),
        .STAT_OFFS (STAT_OFFS),
        .MASK_OFFS (MASK_OFFS)
    ) u_decode (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wide     (bus_wide),
        .stat_wr  (stat_wr),
        .mask_wr  (mask_wr),
        .rd_sel   (rd_sel),
        .rd_upper (rd_upper)
    );

    irq_status_bank #(
        .NUM_SRC      (NUM_SRC),
        .SND_BIT      (SND_BIT),
        .SND_REASSERT (SND_REASSERT)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_pulse),
        .wr_en (stat_wr),
        .wdata (wdata_live),
        .stat  (stat_q)
    );

    irq_mask_reg #(
        .NUM_SRC (NUM_SRC)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mask_wr),
        .wdata (wdata_live),
        .mask  (mask_q)
    );

    irq_req_out #(
        .NUM_SRC (NUM_SRC)
    ) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_q),
        .mask  (mask_q),
        .irq   (irq_req)
    );

    irq_read_port #(
        .NUM_SRC (NUM_SRC)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (rd_sel),
        .rd_upper (rd_upper),
        .rd_wide  (bus_wide),
        .rd_en    (bus_rd),
        .stat     (stat_q),
        .mask     (mask_q),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/irq_ctrl_checks.sv
// Module: irq_ctrl_checks
// Temporal properties of the controller, bound into irq_ctrl_unit.
module irq_ctrl_checks
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC      = 11,
    parameter int unsigned SND_BIT      = 9,
    parameter bit          SND_REASSERT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] mask,
    input lane_wr_t           stat_wr,
    input lane_wr_t           mask_wr,
    input logic [NUM_SRC-1:0] wdata,
    input logic               rd,
    input logic [BUS_W-1:0]   rdata,
    input logic               irq
);

    assert_irq_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat & mask))));

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat & $past(evt)) == $past(evt)));

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt == '0) && !stat_wr.lo && !stat_wr.hi) |=> ((stat & ~$past(stat)) == '0));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr.lo && !wdata[0] && !evt[0]) |=> !stat[0]);

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_wr.lo && !mask_wr.hi) |=> $stable(mask));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    if (SND_REASSERT && (SND_BIT < NUM_SRC) && (SND_BIT < HALF_W)) begin : g_snd
        assert_sound_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr.lo && wdata[SND_BIT]) |=> stat[SND_BIT]);
    end

endmodule

bind irq_ctrl_unit irq_ctrl_checks #(
    .NUM_SRC      (NUM_SRC),
    .SND_BIT      (SND_BIT),
    .SND_REASSERT (SND_REASSERT)
) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_pulse),
    .stat    (stat_q),
    .mask    (mask_q),
    .stat_wr (stat_wr),
    .mask_wr (mask_wr),
    .wdata   (wdata_live),
    .rd      (bus_rd),
    .rdata   (bus_rdata),
    .irq     (irq_req)
);

// File: tb/test_irq_ctrl_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read data, and a monitor pops
// each entry on the falling edge after the read edge.
module test_irq_ctrl_unit;

    localparam int unsigned NSRC = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_pulse = '0;
    logic [11:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic            bus_wide = 1'b1;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl_unit i_irq_ctrl_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );

    function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endfunction

    // A read was sampled at this rising edge.
    always @(posedge clk) rd_seen <= bus_rd & rst_n;

    // Monitor: compare read data after the read edge.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected read", bus_rdata, 32'hdeadbeef);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, bus_rdata, e.exp);
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic w, input logic [31:0] d);
        bus_addr = a; bus_wide = w; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic w, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        exp_q.push_back(e);
        bus_addr = a; bus_wide = w; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        evt_pulse = m;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic pulse_and_wr(input logic [NSRC-1:0] m, input logic [11:0] a, input logic [31:0] d);
        evt_pulse = m; bus_addr = a; bus_wide = 1'b1; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        evt_pulse = '0; bus_wr = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq_req}, 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h070, 1'b1, 32'h0, "R1 status after reset");
        rd(12'h074, 1'b1, 32'h0, "R1 mask after reset");
        check("R1 irq after reset", {31'b0, irq_req}, 32'h0);

        // R2: events latch into status
        pulse(11'h021);
        rd(12'h070, 1'b1, 32'h021, "R2 events set bits 0 and 5");
        check("R6 irq low with mask clear", {31'b0, irq_req}, 32'h0);

        // R6: mask write exposes pending bit 5
        wr(12'h074, 1'b1, 32'h0000_0020);
        check("R6 irq not yet raised at write edge", {31'b0, irq_req}, 32'h0);
        idle(1);
        check("R6 irq raised one cycle after mask write", {31'b0, irq_req}, 32'h1);
        rd(12'h074, 1'b1, 32'h20, "R5 mask read back");

        // R5: unimplemented mask bits read zero
        wr(12'h074, 1'b1, 32'hFFFF_FFFF);
        rd(12'h074, 1'b1, 32'h7FF, "R5 mask upper bits zero");

        // R3: acknowledge by AND-write
        wr(12'h070, 1'b1, 32'hFFFF_FDDF);
        rd(12'h070, 1'b1, 32'h001, "R3 zero clears bit 5, ones keep bit 0");
        wr(12'h070, 1'b1, 32'h0000_0000);
        check("R6 irq still high right after clearing write", {31'b0, irq_req}, 32'h1);
        idle(1);
        check("R6 irq drops one cycle after clearing", {31'b0, irq_req}, 32'h0);
        wr(12'h070, 1'b1, 32'h0000_0401);
        rd(12'h070, 1'b1, 32'h0, "R3 ones do not set non-sound bits");

        // R8: sound bit re-asserted by write
        wr(12'h070, 1'b1, 32'h0000_0200);
        rd(12'h070, 1'b1, 32'h200, "R8 write with bit 9 sets it");
        check("R8 irq from sound bit", {31'b0, irq_req}, 32'h1);
        wr(12'h070, 1'b1, 32'h0);
        rd(12'h070, 1'b1, 32'h0, "R8 sound bit cleared by zero");

        // R4: event beats clearing write
        pulse_and_wr(11'h004, 12'h070, 32'h0);
        rd(12'h070, 1'b1, 32'h004, "R4 event wins over acknowledge");
        wr(12'h070, 1'b1, 32'h0);

        // R7: 16-bit lanes
        pulse(11'h00A);
        rd(12'h070, 1'b0, 32'h00A, "R7 16-bit low half read");
        rd(12'h072, 1'b0, 32'h0, "R7 16-bit high half read");
        wr(12'h072, 1'b0, 32'h0000_0000);
        rd(12'h070, 1'b1, 32'h00A, "R7 high-half write leaves low half");
        wr(12'h070, 1'b0, 32'h0000_FDF7);
        rd(12'h070, 1'b1, 32'h002, "R7 low-half write clears bit 3");
        wr(12'h074, 1'b1, 32'h0);
        wr(12'h074, 1'b0, 32'h0000_0402);
        wr(12'h076, 1'b0, 32'h0000_FFFF);
        rd(12'h074, 1'b0, 32'h402, "R7 mask 16-bit write and read");
        rd(12'h074, 1'b1, 32'h402, "R7 mask unaffected by high-half write");
        check("R6 irq with bit 1 pending and enabled", {31'b0, irq_req}, 32'h1);

        // R10: other offsets ignored
        wr(12'h078, 1'b1, 32'h0);
        wr(12'h06C, 1'b1, 32'hFFFF_FFFF);
        rd(12'h070, 1'b1, 32'h002, "R10 status unchanged by foreign write");
        rd(12'h074, 1'b1, 32'h402, "R10 mask unchanged by foreign write");
        rd(12'h078, 1'b1, 32'h0, "R10 foreign read returns zero");

        // R9: read data held between reads
        rd(12'h074, 1'b1, 32'h402, "R9 read before hold");
        idle(3);
        check("R9 rdata held without read", bus_rdata, 32'h402);

        idle(2);
        if (exp_q.size() != 0) check("R9 pending reads drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
        $finish;
    end

endmodule